// File: doc/BRIEF.md
# Cache Line Storage Array

This block is the tag-and-data store of a direct-mapped cache. It keeps 256 lines. Each line has a valid flag, a dirty flag, a 5-bit tag and four 16-bit words. An 8-bit index picks the line, and bits [2:1] of a 3-bit byte offset pick the word within it. The block has no link to main memory and no miss-handling sequencer. An outside controller drives it, and two control inputs set the kind of access.

With compare high, the block checks the tag: reads return the word and report a hit, and writes update the word only when the access hits. With compare low, the block reads or writes the line directly. Direct access lets the controller read out a victim line for writeback and install a line fetched from memory. Reads are combinational within the cycle. Writes take effect at the rising clock edge.

Top module: `cache_line_array`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the valid and dirty flags of every line.
- R2: While enable is low, every output is 0 and no line is changed.
- R3: hit is 1 exactly when enable and compare are high, the indexed line is valid and its stored tag equals tag_in. hit is 0 whenever compare is low.
- R4: On any enabled access, valid, dirty and tag_out show the indexed line's stored flags and tag. This includes a compare miss, so the controller can decide whether a writeback is needed.
- R5: A compare-write that hits stores data_in into the selected word and sets the line dirty. During that same cycle the dirty output is forced to 0.
- R6: A compare-write that misses leaves the line's data, tag, valid and dirty unchanged.
- R7: A direct write (compare low, write high) stores data_in into the selected word and loads tag_in as the tag. It also loads valid_in into the valid flag and clears the dirty flag.
- R8: A direct read (compare low, write low) returns the selected word, the stored tag, valid and dirty, with hit 0, and changes nothing.
- R9: The selected word is offset[2:1] (0 to 3). Each of the four words of a line is stored and read back independently.
- R10: err is 1 when enable is high and offset[0] is 1. Any write in that cycle is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Access enable |
| index | input | 8 | Line select |
| offset | input | 3 | Byte offset; bits [2:1] select the word |
| comp | input | 1 | 1 = tag-checked access, 0 = direct access |
| write | input | 1 | 1 = write, 0 = read |
| tag_in | input | 5 | Tag to compare or to install |
| data_in | input | 16 | Write data |
| valid_in | input | 1 | Valid value loaded on a direct write |
| hit | output | 1 | Tag-checked access matched a valid line |
| dirty | output | 1 | Stored dirty flag (0 on a compare-write hit) |
| tag_out | output | 5 | Stored tag of the indexed line |
| data_out | output | 16 | Selected stored word |
| valid | output | 1 | Stored valid flag of the indexed line |
| err | output | 1 | Misaligned offset |

## Verification
All outputs are combinational from the inputs and the stored state, so each result is due in the same cycle the stimulus is applied. The bench drives inputs at the falling edge and samples 1 ns later, before the next rising edge. A write becomes visible only after the following rising edge. The bench's reference model therefore applies each update only after checking that cycle's outputs, so the next access sees the new contents. Data and tags that were never written are skipped in comparisons, because storage holds no reset value for them.

// File: rtl/cache_line_array.sv
module cache_line_array #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 5,
  parameter int WORD_W  = 16,
  parameter int WORDS   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [INDEX_W-1:0]  index,
  input  logic [$clog2(WORDS):0] offset,
  input  logic                comp,
  input  logic                write,
  input  logic [TAG_W-1:0]    tag_in,
  input  logic [WORD_W-1:0]   data_in,
  input  logic                valid_in,
  output logic                hit,
  output logic                dirty,
  output logic [TAG_W-1:0]    tag_out,
  output logic [WORD_W-1:0]   data_out,
  output logic                valid,
  output logic                err
);
  localparam int LINES = 1 << INDEX_W;
  localparam int SEL_W = $clog2(WORDS);
  localparam int ADDR_W = INDEX_W + SEL_W;

  logic [WORD_W-1:0] words_q [LINES*WORDS];
  logic [TAG_W-1:0]  tags_q  [LINES];
  logic [LINES-1:0]  valid_q, dirty_q;

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] waddr;
  logic line_v, line_d, match, wr_ok, do_word, do_install, set_dirty;

  assign sel    = offset[SEL_W:1];
  assign waddr  = {index, sel};
  assign line_v = valid_q[index];
  assign line_d = dirty_q[index];
  assign match  = line_v && (tags_q[index] == tag_in);

  assign err      = enable && offset[0];
  assign hit      = enable && comp && match;
  assign valid    = enable && line_v;
  assign dirty    = enable && line_d && !(comp && write && match);
  assign tag_out  = enable ? tags_q[index] : '0;
  assign data_out = enable ? words_q[waddr] : '0;

  assign wr_ok      = enable && write && !offset[0];
  assign do_install = wr_ok && !comp;
  assign set_dirty  = wr_ok && comp && match;
  assign do_word    = do_install || set_dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (do_install) begin
      valid_q[index] <= valid_in;
      dirty_q[index] <= 1'b0;
    end else if (set_dirty) begin
      dirty_q[index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_word)    words_q[waddr] <= data_in;
    if (do_install) tags_q[index]  <= tag_in;
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !hit && !err && !valid && !dirty); // R2
  AST_DISABLED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(valid_q) && $stable(dirty_q)); // R2
  AST_HIT_NEEDS_COMP: assert property (@(posedge clk) disable iff (rst)
    hit |-> enable && comp && valid); // R3
  AST_CW_HIT_DIRTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (enable && comp && write && hit) |-> !dirty); // R5
  AST_CW_HIT_MARKS: assert property (@(posedge clk) disable iff (rst)
    (enable && comp && write && hit && !err) |=> dirty_q[$past(index)]); // R5
  AST_CW_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (enable && comp && write && !hit) |=> $stable(valid_q) && $stable(dirty_q)); // R6
  AST_INSTALL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (enable && !comp && write && !err) |=>
      !dirty_q[$past(index)] && (valid_q[$past(index)] == $past(valid_in))); // R7
  AST_ODD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |=> $stable(valid_q) && $stable(dirty_q)); // R10
endmodule

// File: tb/cache_line_array_test.sv
`timescale 1ns/1ps
module cache_line_array_test;
  logic clk = 1'b0, rst = 1'b1;
  logic enable = 0, comp = 0, write = 0, valid_in = 0;
  logic [7:0] index = 0;
  logic [2:0] offset = 0;
  logic [4:0] tag_in = 0;
  logic [15:0] data_in = 0;
  logic hit, dirty, valid, err;
  logic [4:0] tag_out;
  logic [15:0] data_out;

  int tests = 0, fails = 0;
  int mv [256], md [256], mt [256], mtk [256];
  int mw [1024], mwk [1024];

  always #2.5 clk = ~clk;

  cache_line_array uut (
    .clk(clk), .rst(rst), .enable(enable), .index(index), .offset(offset),
    .comp(comp), .write(write), .tag_in(tag_in), .data_in(data_in),
    .valid_in(valid_in), .hit(hit), .dirty(dirty), .tag_out(tag_out),
    .data_out(data_out), .valid(valid), .err(err));

  task automatic chk(input string r, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic op(input string r, input bit en, input bit c, input bit w,
                    input int idx, input int off, input int tg, input int d, input bit vin);
    int a, m;
    @(negedge clk);
    enable = en; comp = c; write = w; index = idx[7:0]; offset = off[2:0];
    tag_in = tg[4:0]; data_in = d[15:0]; valid_in = vin;
    #1;
    a = idx * 4 + ((off >> 1) & 3);
    m = (mv[idx] != 0 && mtk[idx] != 0 && mt[idx] == tg) ? 1 : 0;
    if (!en) begin
      chk(r, "hit", int'(hit), 0);   chk(r, "valid", int'(valid), 0);
      chk(r, "dirty", int'(dirty), 0); chk(r, "err", int'(err), 0);
      chk(r, "tag_out", int'(tag_out), 0); chk(r, "data_out", int'(data_out), 0);
    end else begin
      chk(r, "hit", int'(hit), c ? m : 0);
      chk(r, "valid", int'(valid), mv[idx]);
      chk(r, "dirty", int'(dirty), (md[idx] != 0 && !(c && w && m != 0)) ? 1 : 0);
      chk(r, "err", int'(err), off & 1);
      if (mtk[idx] != 0) chk(r, "tag_out", int'(tag_out), mt[idx]);
      if (mwk[a] != 0) chk(r, "data_out", int'(data_out), mw[a]);
      if (w && (off & 1) == 0) begin
        if (!c) begin
          mw[a] = d & 16'hffff; mwk[a] = 1; mt[idx] = tg; mtk[idx] = 1;
          mv[idx] = vin; md[idx] = 0;
        end else if (m != 0) begin
          mw[a] = d & 16'hffff; mwk[a] = 1; md[idx] = 1;
        end
      end
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; mtk[i] = 0; end
    for (int i = 0; i < 1024; i++) begin mw[i] = 0; mwk[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: lines empty after reset
    op("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    op("R1", 1, 0, 0, 5, 2, 0, 0, 0);
    op("R1", 1, 0, 0, 255, 6, 0, 0, 0);
    // R7: install line 5, tag 3, all four words
    op("R7", 1, 0, 1, 5, 0, 3, 16'h1111, 1);
    op("R7", 1, 0, 1, 5, 2, 3, 16'hAAAA, 1);
    op("R7", 1, 0, 1, 5, 4, 3, 16'h4444, 1);
    op("R7", 1, 0, 1, 5, 6, 3, 16'h6666, 1);
    // R8 / R9: direct reads of each word
    op("R8", 1, 0, 0, 5, 2, 0, 0, 0);
    op("R9", 1, 0, 0, 5, 0, 0, 0, 0);
    op("R9", 1, 0, 0, 5, 4, 0, 0, 0);
    op("R9", 1, 0, 0, 5, 6, 0, 0, 0);
    // R3 / R4: compare hit and miss
    op("R3", 1, 1, 0, 5, 2, 3, 0, 0);
    op("R4", 1, 1, 0, 5, 2, 4, 0, 0);
    // R5: compare-write hit, then dirty visible on miss
    op("R5", 1, 1, 1, 5, 4, 3, 16'h1234, 0);
    op("R5", 1, 1, 0, 5, 4, 3, 0, 0);
    op("R4", 1, 1, 0, 5, 4, 9, 0, 0);
    // R6: compare-write miss changes nothing
    op("R6", 1, 1, 1, 5, 6, 7, 16'hDEAD, 0);
    op("R6", 1, 0, 0, 5, 6, 0, 0, 0);
    // R7: reinstall clears dirty
    op("R7", 1, 0, 1, 5, 0, 8, 16'h0F0F, 1);
    op("R7", 1, 0, 0, 5, 0, 0, 0, 0);
    // R7 / R3: install with valid_in low then compare misses
    op("R7", 1, 0, 1, 12, 0, 2, 16'h2222, 0);
    op("R3", 1, 1, 0, 12, 0, 2, 0, 0);
    // R10: odd offset flags error, suppresses write
    op("R10", 1, 0, 1, 9, 3, 1, 16'hBEEF, 1);
    op("R10", 1, 0, 0, 9, 2, 0, 0, 0);
    op("R10", 1, 1, 1, 5, 1, 8, 16'h7777, 0);
    op("R10", 1, 1, 0, 5, 0, 8, 0, 0);
    // R2: disabled write has no effect
    op("R2", 0, 0, 1, 5, 0, 1, 16'h5555, 1);
    op("R2", 1, 0, 0, 5, 0, 0, 0, 0);
    // mixed traffic over a few lines and tags
    for (int k = 0; k < 3000; k++) begin
      op("R3", ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
         ($urandom % 4) * 61, $urandom % 8, $urandom % 3, $urandom % 65536, $urandom % 2);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule